// File: doc/BRIEF.md
# Switch Processor Port

This block is the processor-side slave port of a time-division switch. A host reaches it through a small parallel bus. That bus has a 6-bit address, separate 8-bit write and read data paths, an active-low select, a read/write line (high means read), an active-high strobe and an active-low acknowledge. The port holds one 8-bit control register. Through that register it pages the address window onto the switch's three memories:

- the received-sample store ("data memory"), which the host may only read;
- the connection store low, which holds a source address or a message byte;
- the connection store high, which holds three per-channel control bits.

Memory cycles are not served locally. The port places the full memory address, the memory kind, the direction and the write byte on a request bundle towards the switching engine. It waits for a one-cycle grant, then completes the host cycle. Control-register cycles finish locally in one clock. A split setting in the control register lets a host read incoming samples and write connections without reprogramming the select field between the two. The global message flag of the register is exported to the engine.

Top module: `tsw_cpu_port`

## Requirements
- R1: While reset is applied and after it, ack_n is 1, mem_req is 0, msg_mode is 0 and the control register reads 0x00.
- R2: An access with addr[5]=0 reaches the control register whatever addr[4:0] hold. A read returns the register, and a write stores it with bit 5 always read back as 0. ack_n falls one clock after the strobe is sampled, and no memory request is raised.
- R3: For an access with addr[5]=1, mem_addr equals {control[2:0], addr[4:0]}, so control bits 2-0 name the stream and address bits 4-0 the channel.
- R4: With split off, control bits 4-3 pick the memory and appear unchanged on mem_kind: 01 is data memory, 10 is connection low and 11 is connection high.
- R5: With control bit 7 set, every memory read uses kind 01 and every memory write uses kind 10, whatever bits 4-3 hold.
- R6: Control bit 6 is driven on msg_mode.
- R7: A read of connection high (kind 11) returns bits 7-3 as 0 and bits 2-0 from mem_rdata.
- R8: A memory access holds mem_req high until mem_gnt is seen. ack_n falls on the clock after the grant, and a read returns the mem_rdata present in the grant cycle. A write presents mem_we=1 and the write byte on mem_wdata.
- R9: ack_n returns to 1 one clock after strobe is sampled low or sel_n is sampled high. A strobe held active starts no second access.
- R10: A memory access while bits 4-3 are 00 (split off) raises no request and is acknowledged one clock later; a read returns 0x00.
- R11: A memory write with kind 01 selected and split off raises no request and is acknowledged one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select |
| rnw | input | 1 | 1 = read, 0 = write |
| strobe | input | 1 | Active-high data strobe |
| addr | input | 6 | Bit 5 picks memory window; bits 4-0 channel |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, valid while ack_n is 0 |
| ack_n | output | 1 | Active-low transfer complete |
| msg_mode | output | 1 | Global message flag to the engine |
| mem_req | output | 1 | Memory request to the engine |
| mem_gnt | input | 1 | One-cycle grant from the engine |
| mem_we | output | 1 | Request is a write |
| mem_kind | output | 2 | Target memory code |
| mem_addr | output | 8 | Stream and channel address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the grant cycle |

## Verification
The properties assume that the host inputs are already synchronous to clk and that the engine grants only while mem_req is high, for a single cycle, with mem_rdata valid in that cycle. They also assume the host keeps address, direction and data steady from strobe until acknowledge. The stimulus changes every host input on the falling edge. An engine model in the bench answers each request after a fixed delay with one grant pulse, and its read byte is derived from the kind and address it sees, so wrong routing shows up as wrong data.

// File: rtl/tsw_pkg.sv
`timescale 1ns/1ps
package tsw_pkg;
  localparam int CTL_W   = 8;
  localparam int STRM_W  = 3;
  localparam int CMH_W   = 3;
  localparam int SPLIT_B = 7;
  localparam int MSG_B   = 6;
  localparam int FREE_B  = 5;
  localparam int KIND_LO = 3;

  typedef enum logic [1:0] {
    MK_RSVD = 2'b00,
    MK_DM   = 2'b01,
    MK_CML  = 2'b10,
    MK_CMH  = 2'b11
  } mem_kind_e;

  typedef enum logic [1:0] {
    TGT_CTL,
    TGT_MEM,
    TGT_DROP
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DONE
  } bus_st_e;
endpackage

// File: rtl/tsw_ctl_reg.sv
`timescale 1ns/1ps
module tsw_ctl_reg
  import tsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] ctl_q,
  output logic             split,
  output logic             msg,
  output mem_kind_e        sel_kind,
  output logic [STRM_W-1:0] strm
);
  localparam logic [CTL_W-1:0] KEEP_MASK = ~(CTL_W'(1) << FREE_B);

  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wr_data & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign split    = ctl_q[SPLIT_B];
  assign msg      = ctl_q[MSG_B];
  assign sel_kind = mem_kind_e'(ctl_q[KIND_LO+1:KIND_LO]);
  assign strm     = ctl_q[STRM_W-1:0];

  // R2: the unused bit never reads back as 1
  p_free_bit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[FREE_B]);
  // R2: register changes only through a write
  p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/tsw_route.sv
`timescale 1ns/1ps
module tsw_route
  import tsw_pkg::*;
(
  input  logic      is_mem,
  input  logic      rnw,
  input  logic      split,
  input  mem_kind_e sel_kind,
  output tgt_e      tgt,
  output mem_kind_e kind
);
  always_comb begin
    if (split) kind = rnw ? MK_DM : MK_CML;
    else       kind = sel_kind;

    if (!is_mem)                          tgt = TGT_CTL;
    else if (kind == MK_RSVD)             tgt = TGT_DROP;
    else if (kind == MK_DM && !rnw)       tgt = TGT_DROP;
    else                                  tgt = TGT_MEM;
  end
endmodule

// File: rtl/tsw_bus_fsm.sv
`timescale 1ns/1ps
module tsw_bus_fsm
  import tsw_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          strobe,
  input  logic          rnw,
  input  tgt_e          tgt,
  input  mem_kind_e     kind,
  input  logic [AW-1:0] maddr_in,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ctl_rd,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  output logic          ctl_wr,
  output logic          mem_req,
  output logic          mem_we,
  output mem_kind_e     mem_kind,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] rdata,
  output logic          ack_n
);
  localparam logic [DW-1:0] CMH_MASK = DW'((1 << CMH_W) - 1);

  bus_st_e       st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  mem_kind_e     kind_q, kind_d;
  logic          we_q, we_d;
  logic [DW-1:0] wd_q, wd_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          acc;

  assign acc = !sel_n && strobe;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    kind_d = kind_q;
    we_d   = we_q;
    wd_d   = wd_q;
    rd_d   = rd_q;
    ctl_wr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (acc) begin
          case (tgt)
            TGT_CTL: begin
              ctl_wr = !rnw;
              if (rnw) rd_d = ctl_rd;
              st_d = ST_DONE;
            end
            TGT_MEM: begin
              addr_d = maddr_in;
              kind_d = kind;
              we_d   = !rnw;
              wd_d   = wdata;
              st_d   = ST_REQ;
            end
            default: begin
              if (rnw) rd_d = '0;
              st_d = ST_DONE;
            end
          endcase
        end
      end
      ST_REQ: begin
        if (mem_gnt) begin
          if (!we_q) rd_d = (kind_q == MK_CMH) ? (mem_rdata & CMH_MASK) : mem_rdata;
          st_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!strobe || sel_n) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      kind_q <= MK_RSVD;
      we_q   <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      kind_q <= kind_d;
      we_q   <= we_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
    end
  end

  assign mem_req   = (st_q == ST_REQ);
  assign ack_n     = (st_q != ST_DONE);
  assign mem_we    = we_q;
  assign mem_kind  = kind_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign rdata     = rd_q;

  // R8: request stays up until granted
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req);
  // R8: acknowledge after a request only follows a grant
  p_ack_after_gnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) && $past(mem_req) |-> $past(mem_gnt));
  // R9: acknowledge released when strobe drops or select leaves
  p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n && (!strobe || sel_n) |=> ack_n);
  // R9: no new request while the strobe is still held
  p_one_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n && strobe && !sel_n |=> !mem_req);
  // R11: data memory is never written
  p_no_dm_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !(mem_we && mem_kind == MK_DM));
  // R7: connection-high reads carry only the low control bits
  p_cmh_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) && $past(mem_req) && !mem_we && mem_kind == MK_CMH
      |-> rdata[DW-1:CMH_W] == '0);
endmodule

// File: rtl/tsw_cpu_port.sv
`timescale 1ns/1ps
module tsw_cpu_port
  import tsw_pkg::*;
#(
  parameter int CH_W = 5,
  parameter int DW   = 8,
  localparam int AW  = STRM_W + CH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          rnw,
  input  logic          strobe,
  input  logic [CH_W:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ack_n,
  output logic          msg_mode,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [1:0]    mem_kind,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic              rst_meta, rst_sync;
  logic              ctl_wr;
  logic [CTL_W-1:0]  ctl_q;
  logic              split;
  mem_kind_e         sel_kind;
  logic [STRM_W-1:0] strm;
  tgt_e              tgt;
  mem_kind_e         kind;
  mem_kind_e         kind_out;
  logic [AW-1:0]     maddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign maddr = {strm, addr[CH_W-1:0]};

  tsw_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync),
    .wr_en    (ctl_wr),
    .wr_data  (wdata),
    .ctl_q    (ctl_q),
    .split    (split),
    .msg      (msg_mode),
    .sel_kind (sel_kind),
    .strm     (strm)
  );

  tsw_route u_route (
    .is_mem   (addr[CH_W]),
    .rnw      (rnw),
    .split    (split),
    .sel_kind (sel_kind),
    .tgt      (tgt),
    .kind     (kind)
  );

  tsw_bus_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync),
    .sel_n     (sel_n),
    .strobe    (strobe),
    .rnw       (rnw),
    .tgt       (tgt),
    .kind      (kind),
    .maddr_in  (maddr),
    .wdata     (wdata),
    .ctl_rd    (ctl_q),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .ctl_wr    (ctl_wr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_kind  (kind_out),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rdata     (rdata),
    .ack_n     (ack_n)
  );

  assign mem_kind = kind_out;

  // R2: control accesses never reach the engine
  p_ctl_no_req_r2: assert property (@(posedge clk) disable iff (!rst_sync)
    ack_n && !mem_req && !sel_n && strobe && !addr[CH_W] |=> !mem_req);
  // R5: split routes reads to data memory, writes to connection low
  p_split_route_r5: assert property (@(posedge clk) disable iff (!rst_sync)
    mem_req && split |-> (mem_we ? mem_kind == MK_CML : mem_kind == MK_DM));
  // R3: request address is the stream page joined to the channel
  p_addr_page_r3: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(mem_req) |-> mem_addr == {strm, $past(addr[CH_W-1:0])});
  // R10: reserved select never produces a request
  p_rsvd_no_req_r10: assert property (@(posedge clk) disable iff (!rst_sync)
    mem_req |-> mem_kind != MK_RSVD);
endmodule

// File: tb/tsw_cpu_port_test.sv
`timescale 1ns/1ps
module tsw_cpu_port_test;
  localparam int GNT_DLY = 3;
  localparam int NV = 21;

  typedef struct packed {
    logic       rnw;
    logic [5:0] a;
    logic [7:0] wd;
    logic       xreq;
    logic [1:0] xkind;
    logic [7:0] xmaddr;
    logic [7:0] xrd;
    logic [3:0] rq;
  } vec_t;

  // rnw, addr, wdata, request expected, kind, mem address, read byte (local), requirement
  localparam logic [37:0] VEC [0:NV-1] = '{
    {1'b1, 6'h00, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 4'd2},   // R1 reset value, R2
    {1'b0, 6'h1F, 8'h0B, 1'b0, 2'd0, 8'h00, 8'h00, 4'd2},   // R2 odd low bits
    {1'b1, 6'h07, 8'h00, 1'b0, 2'd0, 8'h00, 8'h0B, 4'd2},   // R2
    {1'b1, 6'h25, 8'h00, 1'b1, 2'd1, 8'h65, 8'h00, 4'd3},   // R3 R4 data memory
    {1'b0, 6'h00, 8'h14, 1'b0, 2'd0, 8'h00, 8'h00, 4'd2},
    {1'b0, 6'h3F, 8'h5A, 1'b1, 2'd2, 8'h9F, 8'h00, 4'd4},   // R4 conn low write
    {1'b1, 6'h20, 8'h00, 1'b1, 2'd2, 8'h80, 8'h00, 4'd4},
    {1'b0, 6'h00, 8'h1E, 1'b0, 2'd0, 8'h00, 8'h00, 4'd2},
    {1'b0, 6'h21, 8'hFF, 1'b1, 2'd3, 8'hC1, 8'h00, 4'd4},   // R4 conn high
    {1'b1, 6'h2A, 8'h00, 1'b1, 2'd3, 8'hCA, 8'h00, 4'd7},   // R7 masked read
    {1'b0, 6'h00, 8'h27, 1'b0, 2'd0, 8'h00, 8'h00, 4'd2},
    {1'b1, 6'h12, 8'h00, 1'b0, 2'd0, 8'h00, 8'h07, 4'd2},   // R2 bit 5 reads 0
    {1'b0, 6'h30, 8'h11, 1'b0, 2'd0, 8'h00, 8'h00, 4'd10},  // R10 write dropped
    {1'b1, 6'h30, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 4'd10},  // R10 read gives 0
    {1'b0, 6'h00, 8'h8A, 1'b0, 2'd0, 8'h00, 8'h00, 4'd5},
    {1'b1, 6'h23, 8'h00, 1'b1, 2'd1, 8'h43, 8'h00, 4'd5},   // R5 split read
    {1'b0, 6'h23, 8'h3C, 1'b1, 2'd2, 8'h43, 8'h00, 4'd5},   // R5 split write
    {1'b0, 6'h00, 8'h09, 1'b0, 2'd0, 8'h00, 8'h00, 4'd11},
    {1'b0, 6'h24, 8'h77, 1'b0, 2'd0, 8'h00, 8'h00, 4'd11},  // R11 dm write dropped
    {1'b0, 6'h00, 8'h5B, 1'b0, 2'd0, 8'h00, 8'h00, 4'd6},
    {1'b1, 6'h03, 8'h00, 1'b0, 2'd0, 8'h00, 8'h5B, 4'd6}    // R6
  };

  logic       clk = 1'b0;
  logic       rst_n, sel_n, rnw, strobe, mem_gnt;
  logic [5:0] addr;
  logic [7:0] wdata, rdata, mem_addr, mem_wdata, mem_rdata;
  logic       ack_n, msg_mode, mem_req, mem_we;
  logic [1:0] mem_kind;

  int nchk = 0, nerr = 0, nreq = 0, cnt = 0;
  logic [1:0] cap_kind;
  logic [7:0] cap_addr, cap_wd;
  logic       cap_we;

  always #10 clk = ~clk;

  tsw_cpu_port uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rnw(rnw), .strobe(strobe),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack_n(ack_n),
    .msg_mode(msg_mode), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_we(mem_we), .mem_kind(mem_kind), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] rd_fn(input logic [1:0] k, input logic [7:0] a);
    return a ^ {k, 6'h2D};
  endfunction

  // engine model: grants GNT_DLY falling edges after it first sees a request
  always @(negedge clk) begin
    if (mem_gnt) begin
      mem_gnt <= 1'b0;
      cnt     <= 0;
    end else if (mem_req) begin
      if (cnt == GNT_DLY - 1) begin
        mem_gnt   <= 1'b1;
        mem_rdata <= rd_fn(mem_kind, mem_addr);
        cap_kind  <= mem_kind;
        cap_addr  <= mem_addr;
        cap_we    <= mem_we;
        cap_wd    <= mem_wdata;
        nreq      <= nreq + 1;
        cnt       <= 0;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL R%0d: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // starts an access on a falling edge, returns edges waited until ack
  task automatic access(input logic r, input logic [5:0] a, input logic [7:0] d,
                        output int waited);
    sel_n = 1'b0; rnw = r; addr = a; wdata = d; strobe = 1'b1;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (ack_n && waited < 40);
  endtask

  task automatic release_bus();
    strobe = 1'b0; sel_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R8: watchdog expired, actual hang expected ack");
    finish_run();
  end

  initial begin
    vec_t v;
    int   w, n0;
    logic [7:0] exp_rd;
    rst_n = 1'b0; sel_n = 1'b1; rnw = 1'b1; strobe = 1'b0;
    addr = '0; wdata = '0; mem_gnt = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(1, ack_n, 1'b1);      // R1
    chk(1, mem_req, 1'b0);    // R1
    chk(1, msg_mode, 1'b0);   // R1
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(1, ack_n, 1'b1);      // R1

    for (int i = 0; i < NV; i++) begin
      v  = vec_t'(VEC[i]);
      n0 = nreq;
      access(v.rnw, v.a, v.wd, w);
      chk(int'(v.rq), w, v.xreq ? GNT_DLY + 1 : 1);   // R8 / R2 latency
      chk(int'(v.rq), nreq - n0, v.xreq ? 1 : 0);
      if (v.xreq) begin
        chk(3, cap_addr, v.xmaddr);                   // R3
        chk(int'(v.rq), cap_kind, v.xkind);           // R4 R5
        chk(8, cap_we, !v.rnw);                       // R8
        if (!v.rnw) chk(8, cap_wd, v.wd);             // R8
      end
      if (v.rnw) begin
        exp_rd = v.xrd;
        if (v.xreq) begin
          exp_rd = rd_fn(v.xkind, v.xmaddr);
          if (v.xkind == 2'd3) exp_rd = exp_rd & 8'h07;  // R7
        end
        chk(int'(v.rq), rdata, exp_rd);
      end
      release_bus();
      chk(9, ack_n, 1'b1);                            // R9
    end

    chk(6, msg_mode, 1'b1);   // R6: control bit 6 is set now

    // R9: sel_n leaving while strobe stays high releases ack, no new access
    access(1'b1, 6'h00, 8'h00, w);
    sel_n = 1'b1;
    @(negedge clk);
    chk(9, ack_n, 1'b1);
    @(negedge clk);
    chk(9, ack_n, 1'b1);
    strobe = 1'b0;
    @(negedge clk);

    // R9: held strobe on a memory read yields exactly one request
    n0 = nreq;
    access(1'b1, 6'h2F, 8'h00, w);
    repeat (6) @(negedge clk);
    chk(9, ack_n, 1'b0);
    chk(9, nreq - n0, 1);
    release_bus();
    chk(9, ack_n, 1'b1);

    // R1: reset again restores the control register
    rst_n = 1'b0;
    @(negedge clk);
    chk(1, ack_n, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b1, 6'h00, 8'h00, w);
    chk(1, rdata, 8'h00);
    chk(6, msg_mode, 1'b0);
    release_bus();

    finish_run();
  end
endmodule